// File: doc/BRIEF.md
# Queued Word-Copy DMA Engine

This block accepts copy commands from a small register set and executes them one after another on a single-port memory interface. Software loads a source address, a destination address and two word counts. Writing the destination count captures all four values as one command and places it in a short queue. The engine takes commands from the queue in arrival order. It splits each command into chunks of bounded size, then moves the chunks one word at a time.

There are two modes. In copy-back mode every word read from the source is written to the destination. In stream mode the words leave on a valid/ready output toward a configuration sink, and the destination count has no effect. Each finished command raises two done flags in a write-one-to-clear status register. A level interrupt is asserted whenever a set status flag is not masked. A command written while the queue is full is dropped and raises an overflow flag.

The register port uses byte offsets with a 32-bit write path and a combinational read path. The memory port performs one word access per request. Read data is returned on the cycle after the read request.

Top module: `dmaq_engine`

## Requirements
- R1: After reset, the status register at offset 0x10 reads 0, the mask at offset 0x14 reads 0xFFFFFFFF, the queue status at offset 0x18 reads 0x40000000 (queue empty only), and irq is low.
- R2: A write to the destination count register (offset 0x0C) enqueues one command. The command holds the source address (offset 0x00), the destination address (offset 0x04) and the source count (offset 0x08) as they stand, plus the newly written destination count. Both addresses are enqueued with bits [1:0] cleared.
- R3: The count registers hold a word count of 27 bits, and each word is 4 bytes. Bits [31:27] of a write are discarded and read back as 0.
- R4: In copy-back mode (bit 4 of the mode register at offset 0x1C set), each source word is written to the destination, and both addresses step by 4. The number of words copied is the smaller of the two counts. Any remaining count on the longer side is discarded when the command completes.
- R5: In stream mode (mode bit 4 clear), the source words appear in address order on cfg_data with cfg_valid. Each word is held stable until cfg_ready is high. The destination count is ignored and no memory write is issued.
- R6: Each chunk moves at most CHUNK_WORDS words and never more than the words that remain.
- R7: When a command completes, status bits 13 and 12 are set and the command leaves the queue. A command with nothing to move completes without any data transfer.
- R8: Queued commands are executed strictly in the order they were written, until the queue is empty.
- R9: The queue status register reports queue full at bit 31 and queue empty at bit 30.
- R10: A destination count write while the queue already holds QDEPTH commands is dropped and sets status bit 14.
- R11: Writing a 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R12: irq is high exactly when some status bit is set whose mask bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 5 | Register write byte offset |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_addr | input | 5 | Register read byte offset |
| reg_rd_data | output | 32 | Register read data (combinational) |
| mem_rd_en | output | 1 | Memory word read request |
| mem_wr_en | output | 1 | Memory word write request |
| mem_addr | output | 32 | Memory byte address, word aligned |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid one cycle after mem_rd_en |
| cfg_valid | output | 1 | Stream word valid |
| cfg_ready | input | 1 | Stream sink ready |
| cfg_data | output | 32 | Stream word |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the engine with QDEPTH=4 and CHUNK_WORDS=4. The small chunk size means a ten-word copy crosses two chunk boundaries, and the chunk-size assertion is exercised at its limit instead of never being reached. A held-low cfg_ready keeps the head command stalled, so four short commands fill the queue and a fifth write reaches the overflow path. A toggling cfg_ready exercises the stall-and-hold behaviour of the stream output.

// File: rtl/dmaq_pkg.sv
package dmaq_pkg;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int LEN_W  = 27;
    localparam int REG_AW = 5;

    // register word index = byte offset [4:2]
    typedef enum logic [2:0] {
        RI_SRC_ADDR = 3'd0,
        RI_DST_ADDR = 3'd1,
        RI_SRC_LEN  = 3'd2,
        RI_DST_LEN  = 3'd3,
        RI_STS      = 3'd4,
        RI_MASK     = 3'd5,
        RI_QSTAT    = 3'd6,
        RI_MODE     = 3'd7
    } reg_idx_e;

    localparam int STS_PDONE_BIT = 12;
    localparam int STS_DONE_BIT  = 13;
    localparam int STS_QOVF_BIT  = 14;
    localparam int QST_EMPTY_BIT = 30;
    localparam int QST_FULL_BIT  = 31;
    localparam int MODE_LOOP_BIT = 4;

    localparam logic [DATA_W-1:0] STS_IMPL =
        (DATA_W'(1) << STS_PDONE_BIT) | (DATA_W'(1) << STS_DONE_BIT) |
        (DATA_W'(1) << STS_QOVF_BIT);

    typedef struct packed {
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [LEN_W-1:0]  slen;
        logic [LEN_W-1:0]  dlen;
    } dmaq_cmd_t;

    typedef enum logic [2:0] {
        MV_IDLE,
        MV_CHUNK,
        MV_READ,
        MV_WAIT,
        MV_PUSH,
        MV_FINISH
    } mv_state_e;

    function automatic logic [ADDR_W-1:0] word_align(input logic [ADDR_W-1:0] a);
        return {a[ADDR_W-1:2], 2'b00};
    endfunction

endpackage

// File: rtl/dmaq_cmd_fifo.sv
module dmaq_cmd_fifo
    import dmaq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      push,
    input  dmaq_cmd_t push_cmd,
    input  logic      pop,
    output dmaq_cmd_t head,
    output logic      full,
    output logic      empty,
    output logic      ovf
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    dmaq_cmd_t        slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             push_ok, pop_ok;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign ovf     = push && full;
    assign head    = slots[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) slots[wr_ptr] <= push_cmd;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/dmaq_regs.sv
module dmaq_regs
    import dmaq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              done_set,
    input  logic              ovf_set,
    input  logic              q_full,
    input  logic              q_empty,
    output logic              push,
    output dmaq_cmd_t         push_cmd,
    output logic              loop_mode,
    output logic [DATA_W-1:0] sts,
    output logic              irq
);
    logic [ADDR_W-1:0] src_addr_q, dst_addr_q;
    logic [LEN_W-1:0]  src_len_q, dst_len_q;
    logic [DATA_W-1:0] sts_q, sts_n, mask_q;
    logic              loop_q;
    reg_idx_e          wr_idx, rd_idx;
    logic              wr_hit [8];

    assign wr_idx = reg_idx_e'(wr_addr[4:2]);
    assign rd_idx = reg_idx_e'(rd_addr[4:2]);

    for (genvar g = 0; g < 8; g++) begin : g_dec
        assign wr_hit[g] = wr_en && (wr_addr[4:2] == 3'(g));
    end

    assign push          = wr_hit[RI_DST_LEN];
    assign push_cmd.src  = word_align(src_addr_q);
    assign push_cmd.dst  = word_align(dst_addr_q);
    assign push_cmd.slen = src_len_q;
    assign push_cmd.dlen = wr_data[LEN_W-1:0];

    always_comb begin
        sts_n = sts_q;
        if (wr_hit[RI_STS]) sts_n = sts_n & ~wr_data;
        if (done_set) begin
            sts_n[STS_DONE_BIT]  = 1'b1;
            sts_n[STS_PDONE_BIT] = 1'b1;
        end
        if (ovf_set) sts_n[STS_QOVF_BIT] = 1'b1;
        sts_n = sts_n & STS_IMPL;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            src_addr_q <= '0;
            dst_addr_q <= '0;
            src_len_q  <= '0;
            dst_len_q  <= '0;
            sts_q      <= '0;
            mask_q     <= '1;
            loop_q     <= 1'b0;
        end else begin
            sts_q <= sts_n;
            if (wr_hit[RI_SRC_ADDR]) src_addr_q <= wr_data;
            if (wr_hit[RI_DST_ADDR]) dst_addr_q <= wr_data;
            if (wr_hit[RI_SRC_LEN])  src_len_q  <= wr_data[LEN_W-1:0];
            if (wr_hit[RI_DST_LEN])  dst_len_q  <= wr_data[LEN_W-1:0];
            if (wr_hit[RI_MASK])     mask_q     <= wr_data;
            if (wr_hit[RI_MODE])     loop_q     <= wr_data[MODE_LOOP_BIT];
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_idx)
            RI_SRC_ADDR: rd_data = src_addr_q;
            RI_DST_ADDR: rd_data = dst_addr_q;
            RI_SRC_LEN:  rd_data = DATA_W'(src_len_q);
            RI_DST_LEN:  rd_data = DATA_W'(dst_len_q);
            RI_STS:      rd_data = sts_q;
            RI_MASK:     rd_data = mask_q;
            RI_QSTAT: begin
                rd_data[QST_FULL_BIT]  = q_full;
                rd_data[QST_EMPTY_BIT] = q_empty;
            end
            RI_MODE:     rd_data[MODE_LOOP_BIT] = loop_q;
            default:     rd_data = '0;
        endcase
    end

    assign loop_mode = loop_q;
    assign sts       = sts_q;
    assign irq       = |(sts_q & ~mask_q);
endmodule

// File: rtl/dmaq_mover.sv
module dmaq_mover
    import dmaq_pkg::*;
#(
    parameter int CHUNK_WORDS = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              q_empty,
    input  dmaq_cmd_t         head,
    input  logic              loop_mode,
    output logic              pop,
    output logic              done,
    output logic              chunk_go,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              cfg_valid,
    input  logic              cfg_ready,
    output logic [DATA_W-1:0] cfg_data
);
    localparam logic [LEN_W-1:0]  CHUNK_L = LEN_W'(CHUNK_WORDS);
    localparam logic [ADDR_W-1:0] WSTEP   = ADDR_W'(4);

    mv_state_e         st;
    logic [ADDR_W-1:0] src_a, dst_a;
    logic [LEN_W-1:0]  src_rem, dst_rem, chunk_left, lim;
    logic [DATA_W-1:0] data_q;
    logic              loop_q, step;

    // chunk bound: remaining source, remaining destination in copy-back, chunk cap
    always_comb begin
        lim = src_rem;
        if (loop_mode && (dst_rem < lim)) lim = dst_rem;
        if (lim > CHUNK_L) lim = CHUNK_L;
    end

    assign mem_rd_en = (st == MV_READ);
    assign mem_wr_en = (st == MV_PUSH) && loop_q;
    assign cfg_valid = (st == MV_PUSH) && !loop_q;
    assign mem_addr  = (st == MV_READ) ? src_a : dst_a;
    assign mem_wdata = data_q;
    assign cfg_data  = data_q;
    assign chunk_go  = (st == MV_CHUNK) && (lim != '0);
    assign pop       = (st == MV_FINISH);
    assign done      = (st == MV_FINISH);
    assign step      = (st == MV_PUSH) && (loop_q || cfg_ready);

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= MV_IDLE;
            src_a      <= '0;
            dst_a      <= '0;
            src_rem    <= '0;
            dst_rem    <= '0;
            chunk_left <= '0;
            data_q     <= '0;
            loop_q     <= 1'b0;
        end else begin
            case (st)
                MV_IDLE: if (!q_empty) begin
                    src_a   <= head.src;
                    dst_a   <= head.dst;
                    src_rem <= head.slen;
                    dst_rem <= head.dlen;
                    st      <= MV_CHUNK;
                end
                MV_CHUNK: if (lim == '0) begin
                    st <= MV_FINISH;
                end else begin
                    chunk_left <= lim;
                    loop_q     <= loop_mode;
                    st         <= MV_READ;
                end
                MV_READ: st <= MV_WAIT;
                MV_WAIT: begin
                    data_q <= mem_rdata;
                    st     <= MV_PUSH;
                end
                MV_PUSH: if (step) begin
                    src_a   <= src_a + WSTEP;
                    src_rem <= src_rem - 1'b1;
                    if (loop_q) begin
                        dst_a   <= dst_a + WSTEP;
                        dst_rem <= dst_rem - 1'b1;
                    end
                    chunk_left <= chunk_left - 1'b1;
                    st <= (chunk_left == LEN_W'(1)) ? MV_CHUNK : MV_READ;
                end
                MV_FINISH: st <= MV_IDLE;
                default:   st <= MV_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dmaq_engine.sv
module dmaq_engine
    import dmaq_pkg::*;
#(
    parameter int QDEPTH      = 4,
    parameter int CHUNK_WORDS = 256
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr_en,
    input  logic [4:0]  reg_wr_addr,
    input  logic [31:0] reg_wr_data,
    input  logic [4:0]  reg_rd_addr,
    output logic [31:0] reg_rd_data,
    output logic        mem_rd_en,
    output logic        mem_wr_en,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    output logic        cfg_valid,
    input  logic        cfg_ready,
    output logic [31:0] cfg_data,
    output logic        irq
);
    dmaq_cmd_t         push_cmd, head;
    logic              push, pop, done, ovf, q_full, q_empty, loop_mode, chunk_go;
    logic [DATA_W-1:0] sts;

    dmaq_regs i_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_wr_en),
        .wr_addr  (reg_wr_addr),
        .wr_data  (reg_wr_data),
        .rd_addr  (reg_rd_addr),
        .rd_data  (reg_rd_data),
        .done_set (done),
        .ovf_set  (ovf),
        .q_full   (q_full),
        .q_empty  (q_empty),
        .push     (push),
        .push_cmd (push_cmd),
        .loop_mode(loop_mode),
        .sts      (sts),
        .irq      (irq)
    );

    dmaq_cmd_fifo #(.DEPTH(QDEPTH)) i_fifo (
        .clk     (clk),
        .rst     (rst),
        .push    (push),
        .push_cmd(push_cmd),
        .pop     (pop),
        .head    (head),
        .full    (q_full),
        .empty   (q_empty),
        .ovf     (ovf)
    );

    dmaq_mover #(.CHUNK_WORDS(CHUNK_WORDS)) i_mover (
        .clk      (clk),
        .rst      (rst),
        .q_empty  (q_empty),
        .head     (head),
        .loop_mode(loop_mode),
        .pop      (pop),
        .done     (done),
        .chunk_go (chunk_go),
        .mem_rd_en(mem_rd_en),
        .mem_wr_en(mem_wr_en),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata),
        .cfg_valid(cfg_valid),
        .cfg_ready(cfg_ready),
        .cfg_data (cfg_data)
    );
endmodule

// File: rtl/dmaq_engine_chk.sv
module dmaq_engine_chk #(
    parameter int CHUNK_WORDS = 256
) (
    input logic        clk,
    input logic        rst,
    input logic        mem_rd_en,
    input logic        mem_wr_en,
    input logic [31:0] mem_addr,
    input logic        cfg_valid,
    input logic        cfg_ready,
    input logic [31:0] cfg_data,
    input logic        done,
    input logic        ovf,
    input logic        chunk_go,
    input logic        q_full,
    input logic        q_empty,
    input logic [31:0] sts
);
    int unsigned reads_in_chunk;

    always_ff @(posedge clk) begin
        if (rst || chunk_go) reads_in_chunk <= 0;
        else if (mem_rd_en)  reads_in_chunk <= reads_in_chunk + 1;
    end

    AST_ALIGNED_ADDR: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_en || mem_wr_en) |-> (mem_addr[1:0] == 2'b00)); // R2
    AST_NO_WRITE_IN_STREAM: assert property (@(posedge clk) disable iff (rst)
        cfg_valid |-> !mem_wr_en); // R5
    AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cfg_valid && !cfg_ready) |=> (cfg_valid && $stable(cfg_data))); // R5
    AST_CHUNK_BOUND: assert property (@(posedge clk) disable iff (rst)
        reads_in_chunk <= CHUNK_WORDS); // R6
    AST_DONE_FLAGS: assert property (@(posedge clk) disable iff (rst)
        done |=> (sts[13] && sts[12])); // R7
    AST_FULL_NOT_EMPTY: assert property (@(posedge clk) disable iff (rst)
        !(q_full && q_empty)); // R9
    AST_OVF_FLAG: assert property (@(posedge clk) disable iff (rst)
        ovf |=> sts[14]); // R10
endmodule

bind dmaq_engine dmaq_engine_chk #(.CHUNK_WORDS(CHUNK_WORDS)) i_chk (
    .clk      (clk),
    .rst      (rst),
    .mem_rd_en(mem_rd_en),
    .mem_wr_en(mem_wr_en),
    .mem_addr (mem_addr),
    .cfg_valid(cfg_valid),
    .cfg_ready(cfg_ready),
    .cfg_data (cfg_data),
    .done     (done),
    .ovf      (ovf),
    .chunk_go (chunk_go),
    .q_full   (q_full),
    .q_empty  (q_empty),
    .sts      (sts)
);

// File: tb/test_dmaq_engine.sv
module test_dmaq_engine;
    localparam int CLK_PERIOD = 10;
    localparam int QD = 4;
    localparam int CW = 4;

    localparam logic [4:0] A_SRC = 5'h00, A_DST = 5'h04, A_SLEN = 5'h08, A_DLEN = 5'h0C,
                           A_STS = 5'h10, A_MASK = 5'h14, A_QST = 5'h18, A_MODE = 5'h1C;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic [4:0]  reg_wr_addr = '0;
    logic [31:0] reg_wr_data = '0;
    logic [4:0]  reg_rd_addr = '0;
    logic [31:0] reg_rd_data;
    logic        mem_rd_en, mem_wr_en, cfg_valid, irq;
    logic [31:0] mem_addr, mem_wdata, cfg_data;
    logic [31:0] mem_rdata = '0;
    logic        cfg_ready = 1'b0;

    int checks = 0;
    int failures = 0;
    int rdy_mode = 0;
    logic tog = 1'b0;

    logic [31:0] mem [256];
    logic [31:0] sbuf [64];
    int scnt = 0;
    int wcnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dmaq_engine #(.QDEPTH(QD), .CHUNK_WORDS(CW)) i_dmaq_engine (
        .clk(clk), .rst(rst),
        .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
        .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_data(cfg_data),
        .irq(irq)
    );

    function automatic logic [31:0] pat(input int i);
        return 32'hC0DE_0000 | 32'(i);
    endfunction

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = pat(i);
    end

    always @(posedge clk) begin
        if (mem_wr_en) begin
            mem[mem_addr[9:2]] <= mem_wdata;
            wcnt <= wcnt + 1;
        end
        if (mem_rd_en) mem_rdata <= mem[mem_addr[9:2]];
        if (cfg_valid && cfg_ready) begin
            if (scnt < 64) sbuf[scnt] <= cfg_data;
            scnt <= scnt + 1;
        end
    end

    always @(negedge clk) begin
        tog <= ~tog;
        cfg_ready <= (rdy_mode == 1) || (rdy_mode == 2 && tog);
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd_addr = a;
        #1 d = reg_rd_data;
    endtask

    task automatic wait_empty(input string req);
        logic [31:0] q;
        bit seen = 0;
        for (int n = 0; n < 3000 && !seen; n++) begin
            rd(A_QST, q);
            seen = q[30];
        end
        check(seen, req, {31'd0, seen}, 32'd1);
    endtask

    task automatic cmd(input logic [31:0] s, input logic [31:0] d, input logic [31:0] sl, input logic [31:0] dl);
        wr(A_SRC, s); wr(A_DST, d); wr(A_SLEN, sl); wr(A_DLEN, dl);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(A_STS, v);  check(v == 32'h0, "R1 sts", v, 32'h0);
        rd(A_MASK, v); check(v == 32'hFFFF_FFFF, "R1 mask", v, 32'hFFFF_FFFF);
        rd(A_QST, v);  check(v == 32'h4000_0000, "R1 qstat", v, 32'h4000_0000);
        check(irq == 1'b0, "R1 irq", {31'd0, irq}, 32'h0);
    endtask

    task automatic t_len_width;
        logic [31:0] v;
        wr(A_SLEN, 32'hFFFF_FFFF);
        rd(A_SLEN, v); check(v == 32'h07FF_FFFF, "R3 count width", v, 32'h07FF_FFFF);
        wr(A_SLEN, 32'h0);
    endtask

    task automatic t_copy_basic;
        logic [31:0] v;
        wr(A_STS, 32'hFFFF_FFFF);
        wr(A_MODE, 32'h10);
        cmd(32'h0000_0043, 32'h0000_0202, 32'd6, 32'd6);
        wait_empty("R8 copy drains");
        for (int k = 0; k < 6; k++)
            check(mem[128+k] == pat(16+k), "R2 R4 copy word", mem[128+k], pat(16+k));
        check(mem[134] == pat(134), "R4 past end untouched", mem[134], pat(134));
        rd(A_STS, v); check(v == 32'h3000, "R7 done flags", v, 32'h3000);
        check(irq == 1'b0, "R12 masked irq", {31'd0, irq}, 32'h0);
    endtask

    task automatic t_irq_w1c;
        logic [31:0] v;
        wr(A_MASK, 32'hFFFF_DFFF);
        check(irq == 1'b1, "R12 unmasked irq", {31'd0, irq}, 32'h1);
        wr(A_STS, 32'h0000_2000);
        rd(A_STS, v); check(v == 32'h1000, "R11 w1c one bit", v, 32'h1000);
        check(irq == 1'b0, "R12 irq after clear", {31'd0, irq}, 32'h0);
        wr(A_STS, 32'h0);
        rd(A_STS, v); check(v == 32'h1000, "R11 write zero keeps", v, 32'h1000);
        wr(A_STS, 32'h1000);
        rd(A_STS, v); check(v == 32'h0, "R11 cleared", v, 32'h0);
        wr(A_MASK, 32'hFFFF_FFFF);
    endtask

    task automatic t_copy_unequal;
        logic [31:0] v;
        wr(A_MODE, 32'h10);
        cmd(32'h0000_0080, 32'h0000_0280, 32'd3, 32'd7);
        wait_empty("R4 unequal drains");
        for (int k = 0; k < 3; k++)
            check(mem[160+k] == pat(32+k), "R4 min count copy", mem[160+k], pat(32+k));
        check(mem[163] == pat(163), "R4 longer side discarded", mem[163], pat(163));
        rd(A_STS, v); check(v == 32'h3000, "R7 unequal done", v, 32'h3000);
        wr(A_STS, 32'hFFFF_FFFF);
    endtask

    task automatic t_copy_chunks;
        wr(A_MODE, 32'h10);
        cmd(32'h0000_0000, 32'h0000_0300, 32'd10, 32'd10);
        wait_empty("R6 multi chunk drains");
        for (int k = 0; k < 10; k++)
            check(mem[192+k] == pat(k), "R6 multi chunk word", mem[192+k], pat(k));
        check(mem[202] == pat(202), "R6 past end untouched", mem[202], pat(202));
        wr(A_STS, 32'hFFFF_FFFF);
    endtask

    task automatic t_stream;
        logic [31:0] v;
        int s0, w0;
        s0 = scnt; w0 = wcnt;
        wr(A_MODE, 32'h0);
        rdy_mode = 2;
        cmd(32'h0000_0101, 32'h0000_0380, 32'd5, 32'd9);
        wait_empty("R5 stream drains");
        check(scnt - s0 == 5, "R5 stream count", 32'(scnt - s0), 32'd5);
        for (int k = 0; k < 5; k++)
            check(sbuf[s0+k] == pat(64+k), "R5 stream word", sbuf[s0+k], pat(64+k));
        check(wcnt == w0, "R5 no mem write", 32'(wcnt - w0), 32'd0);
        rd(A_STS, v); check(v == 32'h3000, "R7 stream done", v, 32'h3000);
        wr(A_STS, 32'hFFFF_FFFF);
    endtask

    task automatic t_zero_len;
        logic [31:0] v;
        int s0;
        s0 = scnt;
        wr(A_MODE, 32'h0);
        cmd(32'h0000_0010, 32'h0000_0000, 32'd0, 32'd0);
        wait_empty("R7 zero drains");
        rd(A_STS, v); check(v == 32'h3000, "R7 zero length done", v, 32'h3000);
        check(scnt == s0, "R7 zero length no data", 32'(scnt - s0), 32'd0);
        wr(A_STS, 32'hFFFF_FFFF);
    endtask

    task automatic t_overflow;
        logic [31:0] v;
        int s0;
        int lens [4] = '{2, 1, 3, 2};
        int bases [4] = '{40, 44, 48, 52};
        int idx;
        s0 = scnt;
        wr(A_MODE, 32'h0);
        rdy_mode = 0;
        for (int c = 0; c < 4; c++)
            cmd(32'(bases[c] * 4), 32'h0, 32'(lens[c]), 32'h0);
        rd(A_QST, v); check(v == 32'h8000_0000, "R9 queue full", v, 32'h8000_0000);
        rd(A_STS, v); check(v == 32'h0, "R10 no ovf yet", v, 32'h0);
        cmd(32'(56 * 4), 32'h0, 32'd4, 32'h0);
        rd(A_STS, v); check(v == 32'h4000, "R10 ovf flag", v, 32'h4000);
        rdy_mode = 1;
        wait_empty("R8 queue drains");
        check(scnt - s0 == 8, "R10 dropped cmd absent", 32'(scnt - s0), 32'd8);
        idx = s0;
        for (int c = 0; c < 4; c++)
            for (int k = 0; k < lens[c]; k++) begin
                check(sbuf[idx] == pat(bases[c] + k), "R8 order", sbuf[idx], pat(bases[c] + k));
                idx++;
            end
        rd(A_STS, v); check(v == 32'h7000, "R7 R10 flags", v, 32'h7000);
    endtask

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_len_width();
        t_copy_basic();
        t_irq_w1c();
        t_copy_unequal();
        t_copy_chunks();
        t_stream();
        t_zero_len();
        t_overflow();
        finish_run();
    end
endmodule